// File: doc/BRIEF.md
# Programmable Panel Sync Timing Generator

This block produces the raster timing for a flat panel: a line sync, a frame sync, a data-enable window, a pixel strobe that marks when the panel should sample, and the column and row of the current active pixel. All timing comes from configuration fields that a host holds steady on the block's inputs. The block samples those fields into shadow registers only when it is switched on and at each frame boundary, so a frame that has already started always finishes with the settings it began with.

A pixel period is either one core clock, in bypass mode, or an even number of core clocks set by a divider field. Each line runs through sync, back porch, active and front porch, in that order. The vertical counter moves on by one at the end of each completed line. The horizontal active count is taken from the pixel width for TFT panels. For STN panels it is converted from the pixel width into interface transfers.

Top module: `lcd_sync_gen`

## Requirements
- R1: With `bypass` low, `pixStb` is high for one cycle in every 2*(`clkDiv`+1) core cycles. The first strobe after enabling falls in the last cycle of the first such period. Each pixel position holds for one whole period.
- R2: With `bypass` high, `pixStb` is high in every cycle while the block runs.
- R3: A line has four phases in this order: sync for `hSyncM1`+1 pixels, back porch for `hBackM1`+1, active for the derived active count, and front porch for `hFrontM1`+1. Within a line, `xPos` increases by one on each strobed active pixel.
- R4: A frame has four phases, counted in lines, in this order: `vSyncM1`+1 lines of frame sync, `vBack` lines of back porch, `linesM1`+1 active lines, and `vFront` lines of front porch. `vBack` and `vFront` are raw counts and may be zero. The line counter advances once per completed line.
- R5: `de` is high only where an active column meets an active row. There, `xPos` and `yPos` give the zero-based active column and row. Outside that area both are zero.
- R6: The sync outputs are active high when `invLine` and `invFrame` are 0, and active low when they are 1.
- R7: The active count is derived from `widthM1`+1 pixels as follows. `panelMode` 2'b00 (TFT) uses the pixel count unchanged. 2'b01 (mono STN) and 2'b10/2'b11 (colour STN) are STN modes; colour STN first multiplies the count by three. STN then divides by 4, rounding up, when `ifNarrow`=1 (4-bit bus) or `dualScan`=1. Otherwise STN divides by 8, rounding up.
- R8: All configuration inputs are sampled when the block is enabled and on the pixel strobe that ends a frame. A change at any other time first shows in the next frame.
- R9: While `enable` is low, `de`, `pixStb`, `xPos` and `yPos` are 0, and `hsync`/`vsync` rest at the inactive level given by the live invert inputs. Enabling again restarts from the first sync pixel of a frame.
- R10: After reset, the block is in the disabled state of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the timing generator |
| bypass | input | 1 | One pixel per core cycle |
| clkDiv | input | DIV_W | Divider value; period is 2*(clkDiv+1) cycles |
| hSyncM1 | input | HP_W | Line sync width minus one |
| hBackM1 | input | HP_W | Line back porch minus one |
| hFrontM1 | input | HP_W | Line front porch minus one |
| widthM1 | input | H_W | Active pixels per line minus one |
| vSyncM1 | input | VS_W | Frame sync lines minus one |
| vBack | input | VP_W | Frame back porch lines |
| vFront | input | VP_W | Frame front porch lines |
| linesM1 | input | V_W | Active lines minus one |
| invLine | input | 1 | Line sync active low |
| invFrame | input | 1 | Frame sync active low |
| panelMode | input | 2 | 00 TFT, 01 mono STN, 1x colour STN |
| ifNarrow | input | 1 | STN interface is 4 bits wide |
| dualScan | input | 1 | STN dual scan |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable |
| pixStb | output | 1 | Pixel strobe |
| xPos | output | H_W | Active column |
| yPos | output | V_W | Active row |

## Verification
The pixel strobe is combinational, so it shows in the same cycle its period ends. Counters and shadowed settings change at the clock edge that follows a strobe, and they reach the outputs in the cycle after that edge. Enabling takes one cycle before the first sync pixel appears, while disabling silences the outputs in the same cycle. The bench runs a cycle-level model of these rules. It advances the model once for each rising edge, using the inputs that edge will see, and compares every output at the falling edge that follows. Configuration changes are applied only just after a falling edge, so the model and the design sample the same values.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  typedef enum logic [1:0] {
    PANEL_TFT       = 2'b00,
    PANEL_STN_MONO  = 2'b01,
    PANEL_STN_COLOR = 2'b10,
    PANEL_STN_COLX  = 2'b11
  } panelKind_t;

  // strobes from the control half to the counters
  typedef struct packed {
    logic active;   // running and enabled
    logic pixStb;   // end of a pixel period
    logic loadCfg;  // sample configuration into shadows
  } ctrlStrobes_t;

endpackage

// File: rtl/lcd_sync_hcount.sv
module lcd_sync_hcount
  import lcd_sync_pkg::*;
#(
  parameter int H_W  = 11,
  parameter int HC_W = 12
) (
  input  logic [H_W-1:0]  widthM1,
  input  logic [1:0]      panelMode,
  input  logic            ifNarrow,
  input  logic            dualScan,
  output logic [HC_W-1:0] hActCount
);
  localparam int SW = HC_W + 2;

  panelKind_t     kind;
  logic [SW-1:0]  pixels;
  logic [SW-1:0]  scaled;
  logic [SW-1:0]  byQuarter;
  logic [SW-1:0]  byEighth;

  always_comb begin
    kind      = panelKind_t'(panelMode);
    pixels    = SW'(widthM1) + SW'(1);
    scaled    = (kind == PANEL_STN_COLOR || kind == PANEL_STN_COLX) ? pixels * SW'(3) : pixels;
    byQuarter = (scaled + SW'(3)) >> 2;
    byEighth  = (scaled + SW'(7)) >> 3;
    if (kind == PANEL_TFT)
      hActCount = HC_W'(pixels);
    else if (ifNarrow || dualScan)
      hActCount = HC_W'(byQuarter);
    else
      hActCount = HC_W'(byEighth);
  end
endmodule

// File: rtl/lcd_sync_ctrl.sv
module lcd_sync_ctrl
  import lcd_sync_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             bypass,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             lastPix,
  output ctrlStrobes_t     strb
);
  logic             running;
  logic             shBypass;
  logic [DIV_W-1:0] shDiv;
  logic [DIV_W:0]   divCnt;
  logic [DIV_W:0]   divLim;
  logic             active;
  logic             tick;
  logic             load;

  always_comb begin
    divLim = {shDiv, 1'b1};
    active = running && enable;
    tick   = active && (shBypass || divCnt == divLim);
    load   = (enable && !running) || (tick && lastPix);
    strb.active  = active;
    strb.pixStb  = tick;
    strb.loadCfg = load;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      shBypass <= 1'b0;
      shDiv    <= '0;
      divCnt   <= '0;
    end else begin
      running <= enable;
      if (load) begin
        shBypass <= bypass;
        shDiv    <= clkDiv;
      end
      if (!active || tick)
        divCnt <= '0;
      else
        divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_sync_dp.sv
module lcd_sync_dp
  import lcd_sync_pkg::*;
#(
  parameter int HP_W = 8,
  parameter int H_W  = 11,
  parameter int HC_W = 12,
  parameter int VS_W = 6,
  parameter int VP_W = 8,
  parameter int V_W  = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strb,
  input  logic [HP_W-1:0] hSyncM1,
  input  logic [HP_W-1:0] hBackM1,
  input  logic [HP_W-1:0] hFrontM1,
  input  logic [HC_W-1:0] hActCount,
  input  logic [VS_W-1:0] vSyncM1,
  input  logic [VP_W-1:0] vBack,
  input  logic [VP_W-1:0] vFront,
  input  logic [V_W-1:0]  linesM1,
  input  logic            invLine,
  input  logic            invFrame,
  output logic            lastPix,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic [H_W-1:0]  xPos,
  output logic [V_W-1:0]  yPos
);
  localparam int HT_W = HC_W + 2;
  localparam int VT_W = V_W + 2;
  localparam logic [HT_W-1:0] H_ONE = HT_W'(1);
  localparam logic [VT_W-1:0] V_ONE = VT_W'(1);

  // shadow copies, stable for a whole frame
  logic [HP_W-1:0] shHSync, shHBack, shHFront;
  logic [HC_W-1:0] shAct;
  logic [VS_W-1:0] shVSync;
  logic [VP_W-1:0] shVBack, shVFront;
  logic [V_W-1:0]  shLines;
  logic            shInvLine, shInvFrame;

  logic [HT_W-1:0] hCnt, hSyncEnd, hActStart, hActEnd, hTotal;
  logic [VT_W-1:0] vCnt, vSyncEnd, vActStart, vActEnd, vTotal;
  logic            hLast, vLast, inHSync, inVSync, hAct, vAct, deInt;

  always_comb begin
    hSyncEnd  = HT_W'(shHSync) + H_ONE;
    hActStart = hSyncEnd + HT_W'(shHBack) + H_ONE;
    hActEnd   = hActStart + HT_W'(shAct);
    hTotal    = hActEnd + HT_W'(shHFront) + H_ONE;
    vSyncEnd  = VT_W'(shVSync) + V_ONE;
    vActStart = vSyncEnd + VT_W'(shVBack);
    vActEnd   = vActStart + VT_W'(shLines) + V_ONE;
    vTotal    = vActEnd + VT_W'(shVFront);

    hLast   = (hCnt == hTotal - H_ONE);
    vLast   = (vCnt == vTotal - V_ONE);
    lastPix = hLast && vLast;

    inHSync = hCnt < hSyncEnd;
    inVSync = vCnt < vSyncEnd;
    hAct    = (hCnt >= hActStart) && (hCnt < hActEnd);
    vAct    = (vCnt >= vActStart) && (vCnt < vActEnd);
    deInt   = strb.active && hAct && vAct;

    hsync = strb.active ? (inHSync ^ shInvLine)  : invLine;
    vsync = strb.active ? (inVSync ^ shInvFrame) : invFrame;
    de    = deInt;
    xPos  = deInt ? H_W'(hCnt - hActStart) : '0;
    yPos  = deInt ? V_W'(vCnt - vActStart) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shHSync <= '0; shHBack <= '0; shHFront <= '0; shAct <= '0;
      shVSync <= '0; shVBack <= '0; shVFront <= '0; shLines <= '0;
      shInvLine <= 1'b0; shInvFrame <= 1'b0;
    end else if (strb.loadCfg) begin
      shHSync <= hSyncM1; shHBack <= hBackM1; shHFront <= hFrontM1; shAct <= hActCount;
      shVSync <= vSyncM1; shVBack <= vBack; shVFront <= vFront; shLines <= linesM1;
      shInvLine <= invLine; shInvFrame <= invFrame;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!strb.active) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strb.pixStb) begin
      if (hLast) begin
        hCnt <= '0;
        vCnt <= vLast ? '0 : vCnt + V_ONE;
      end else begin
        hCnt <= hCnt + H_ONE;
      end
    end
  end
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int HP_W  = 8,
  parameter int H_W   = 11,
  parameter int VS_W  = 6,
  parameter int VP_W  = 8,
  parameter int V_W   = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             bypass,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [HP_W-1:0]  hSyncM1,
  input  logic [HP_W-1:0]  hBackM1,
  input  logic [HP_W-1:0]  hFrontM1,
  input  logic [H_W-1:0]   widthM1,
  input  logic [VS_W-1:0]  vSyncM1,
  input  logic [VP_W-1:0]  vBack,
  input  logic [VP_W-1:0]  vFront,
  input  logic [V_W-1:0]   linesM1,
  input  logic             invLine,
  input  logic             invFrame,
  input  logic [1:0]       panelMode,
  input  logic             ifNarrow,
  input  logic             dualScan,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             pixStb,
  output logic [H_W-1:0]   xPos,
  output logic [V_W-1:0]   yPos
);
  localparam int HC_W = H_W + 1;

  ctrlStrobes_t    strb;
  logic            lastPix;
  logic [HC_W-1:0] hActCount;

  lcd_sync_hcount #(.H_W(H_W), .HC_W(HC_W)) u_hcount (
    .widthM1(widthM1), .panelMode(panelMode), .ifNarrow(ifNarrow),
    .dualScan(dualScan), .hActCount(hActCount)
  );

  lcd_sync_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .bypass(bypass),
    .clkDiv(clkDiv), .lastPix(lastPix), .strb(strb)
  );

  lcd_sync_dp #(
    .HP_W(HP_W), .H_W(H_W), .HC_W(HC_W), .VS_W(VS_W), .VP_W(VP_W), .V_W(V_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hSyncM1(hSyncM1), .hBackM1(hBackM1), .hFrontM1(hFrontM1), .hActCount(hActCount),
    .vSyncM1(vSyncM1), .vBack(vBack), .vFront(vFront), .linesM1(linesM1),
    .invLine(invLine), .invFrame(invFrame), .lastPix(lastPix),
    .hsync(hsync), .vsync(vsync), .de(de), .xPos(xPos), .yPos(yPos)
  );

  assign pixStb = strb.pixStb;
endmodule

// File: rtl/lcd_sync_chk.sv
module lcd_sync_chk #(
  parameter int H_W = 11,
  parameter int V_W = 11
) (
  input logic           clk,
  input logic           rstN,
  input logic           enable,
  input logic           de,
  input logic           pixStb,
  input logic [H_W-1:0] xPos,
  input logic [V_W-1:0] yPos
);
  // R9
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!de && !pixStb && xPos == '0 && yPos == '0));

  // R1
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$past(pixStb)) |-> ($stable(xPos) && $stable(yPos)));

  // R3
  x_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && $past(pixStb) && $past(de) && de)
      |-> (xPos == $past(xPos) + 1'b1));

  // R5
  line_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(de) |-> (xPos == '0));
endmodule

bind lcd_sync_gen lcd_sync_chk #(.H_W(H_W), .V_W(V_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .de(de),
  .pixStb(pixStb), .xPos(xPos), .yPos(yPos)
);

// File: tb/lcd_sync_gen_test.sv
`timescale 1ns/1ps
module lcd_sync_gen_test;
  localparam int DIV_W = 8, HP_W = 8, H_W = 11, VS_W = 6, VP_W = 8, V_W = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  always #4 clk = ~clk;

  // configuration as plain counts
  int cHsw = 2, cHbp = 1, cHfp = 1, cW = 4;
  int cVsw = 1, cVbp = 1, cVfp = 0, cLines = 2;
  int cDiv = 0, cByp = 1, cInvL = 0, cInvF = 0;
  int cPanel = 0, cNarrow = 0, cDual = 0;

  logic             hsync, vsync, de, pixStb;
  logic [H_W-1:0]   xPos;
  logic [V_W-1:0]   yPos;

  lcd_sync_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .bypass(cByp[0]),
    .clkDiv(DIV_W'(cDiv)), .hSyncM1(HP_W'(cHsw - 1)), .hBackM1(HP_W'(cHbp - 1)),
    .hFrontM1(HP_W'(cHfp - 1)), .widthM1(H_W'(cW - 1)), .vSyncM1(VS_W'(cVsw - 1)),
    .vBack(VP_W'(cVbp)), .vFront(VP_W'(cVfp)), .linesM1(V_W'(cLines - 1)),
    .invLine(cInvL[0]), .invFrame(cInvF[0]), .panelMode(cPanel[1:0]),
    .ifNarrow(cNarrow[0]), .dualScan(cDual[0]),
    .hsync(hsync), .vsync(vsync), .de(de), .pixStb(pixStb), .xPos(xPos), .yPos(yPos)
  );

  int checks = 0, errors = 0;

  // bench reference state
  int run = 0, mh = 0, mv = 0, md = 0;
  int sHsw, sHbp, sHfp, sAct, sVsw, sVbp, sVfp, sLines, sP, sByp, sInvL, sInvF;

  function automatic int activeCount();
    int n;
    n = cW;
    if (cPanel == 0) return n;
    if (cPanel >= 2) n = n * 3;
    if (cNarrow != 0 || cDual != 0) return (n + 3) / 4;
    return (n + 7) / 8;
  endfunction

  task automatic modelLoad();
    sHsw = cHsw; sHbp = cHbp; sHfp = cHfp; sAct = activeCount();
    sVsw = cVsw; sVbp = cVbp; sVfp = cVfp; sLines = cLines;
    sP = 2 * (cDiv + 1); sByp = cByp; sInvL = cInvL; sInvF = cInvF;
  endtask

  // advance by one rising edge, using inputs that edge will see
  task automatic modelStep();
    int hT, vT;
    if (!enable) begin
      run = 0; mh = 0; mv = 0; md = 0;
    end else if (run == 0) begin
      run = 1; mh = 0; mv = 0; md = 0; modelLoad();
    end else begin
      hT = sHsw + sHbp + sAct + sHfp;
      vT = sVsw + sVbp + sLines + sVfp;
      if (sByp != 0 || md == sP - 1) begin
        md = 0;
        if (mh == hT - 1) begin
          mh = 0;
          if (mv == vT - 1) begin mv = 0; modelLoad(); end
          else mv = mv + 1;
        end else mh = mh + 1;
      end else md = md + 1;
    end
  endtask

  task automatic checkNow(string tag);
    int eHs, eVs, eDe, eStb, eX, eY, hA, vA;
    if (run != 0 && enable) begin
      hA  = (mh >= sHsw + sHbp) && (mh < sHsw + sHbp + sAct);
      vA  = (mv >= sVsw + sVbp) && (mv < sVsw + sVbp + sLines);
      eDe = hA && vA;
      eHs = (mh < sHsw) ^ sInvL;
      eVs = (mv < sVsw) ^ sInvF;
      eStb = (sByp != 0) || (md == sP - 1);
      eX  = eDe ? mh - sHsw - sHbp : 0;
      eY  = eDe ? mv - sVsw - sVbp : 0;
    end else begin
      eDe = 0; eHs = cInvL; eVs = cInvF; eStb = 0; eX = 0; eY = 0;
    end
    checks++;
    if (hsync !== eHs[0] || vsync !== eVs[0] || de !== eDe[0] || pixStb !== eStb[0] ||
        int'(xPos) != eX || int'(yPos) != eY) begin
      errors++;
      $display("FAIL %s t=%0t actual hs=%b vs=%b de=%b stb=%b x=%0d y=%0d expected hs=%0d vs=%0d de=%0d stb=%0d x=%0d y=%0d",
               tag, $time, hsync, vsync, de, pixStb, xPos, yPos, eHs, eVs, eDe, eStb, eX, eY);
    end
  endtask

  task automatic runCycles(int n, string tag);
    for (int i = 0; i < n; i++) begin
      modelStep();
      @(negedge clk);
      checkNow(tag);
    end
  endtask

  task automatic stopBlock();
    enable = 1'b0;
    runCycles(3, "R9");
  endtask

  // R10: disabled state out of reset
  task automatic testReset();
    repeat (3) @(negedge clk);
    checkNow("R10");
    rstN = 1'b1;
    runCycles(2, "R10");
  endtask

  // R2 R3 R4 R5: basic bypass frame, two frames
  task automatic testBypass();
    cByp = 1; cHsw = 2; cHbp = 1; cW = 4; cHfp = 1;
    cVsw = 1; cVbp = 1; cLines = 2; cVfp = 0;
    enable = 1'b1;
    runCycles(70, "R2");
    stopBlock();
  endtask

  // R1: divided pixel clock
  task automatic testDivider();
    cByp = 0; cDiv = 1;
    enable = 1'b1;
    runCycles(140, "R1");
    cDiv = 2;
    enable = 1'b0; runCycles(2, "R9");
    enable = 1'b1;
    runCycles(60, "R1");
    stopBlock();
    cByp = 1; cDiv = 0;
  endtask

  // R4: zero raw porches with minimum minus-one fields
  task automatic testMinimum();
    cHsw = 1; cHbp = 1; cHfp = 1; cW = 1;
    cVsw = 1; cVbp = 0; cVfp = 0; cLines = 1;
    enable = 1'b1;
    runCycles(30, "R4");
    stopBlock();
    cVbp = 2; cVfp = 3; cVsw = 2; cLines = 3; cW = 3;
    enable = 1'b1;
    runCycles(120, "R4");
    stopBlock();
  endtask

  // R6: inverted polarity
  task automatic testPolarity();
    cHsw = 2; cHbp = 1; cW = 4; cHfp = 1; cVsw = 1; cVbp = 1; cLines = 2; cVfp = 0;
    cInvL = 1; cInvF = 1;
    runCycles(2, "R6");
    enable = 1'b1;
    runCycles(40, "R6");
    stopBlock();
    cInvL = 0; cInvF = 1;
    enable = 1'b1;
    runCycles(40, "R6");
    stopBlock();
    cInvF = 0;
  endtask

  // R7: STN line-size conversion
  task automatic testStn();
    cPanel = 1; cNarrow = 0; cDual = 0; cW = 20;      // 3 transfers
    enable = 1'b1; runCycles(60, "R7"); stopBlock();
    cPanel = 2; cNarrow = 1; cDual = 0; cW = 5;       // 15 -> 4
    enable = 1'b1; runCycles(60, "R7"); stopBlock();
    cPanel = 1; cNarrow = 0; cDual = 1; cW = 9;       // 3
    enable = 1'b1; runCycles(60, "R7"); stopBlock();
    cPanel = 3; cNarrow = 0; cDual = 0; cW = 6;       // 18 -> 3
    enable = 1'b1; runCycles(60, "R7"); stopBlock();
    cPanel = 0; cNarrow = 0; cDual = 0; cW = 4;
  endtask

  // R8: mid-frame change waits for next frame
  task automatic testShadow();
    enable = 1'b1;
    runCycles(10, "R8");
    cW = 6; cHsw = 3; cInvL = 1; cLines = 3; cByp = 0; cDiv = 0;
    runCycles(140, "R8");
    stopBlock();
    cW = 4; cHsw = 2; cInvL = 0; cLines = 2; cByp = 1;
  endtask

  // R9: disable mid-frame then restart
  task automatic testDisable();
    enable = 1'b1;
    runCycles(13, "R9");
    enable = 1'b0;
    runCycles(2, "R9");
    cInvL = 1;
    runCycles(3, "R9");
    cInvL = 0;
    enable = 1'b1;
    runCycles(40, "R9");
    stopBlock();
  endtask

  initial begin
    testReset();
    testBypass();
    testDivider();
    testMinimum();
    testPolarity();
    testStn();
    testShadow();
    testDisable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule